// File: doc/BRIEF.md
# EEPROM Page Write Controller

This block is the synchronous write-side sequencer for a paged 16-bit EEPROM array. It watches active-low chip-select, write-enable and output-enable strobes that have already been sampled into the clock domain. Each qualified strobe pulse is treated as one word load. Its address is taken when the strobe pair first goes active, and its data when the pair releases. The word is placed in a page buffer indexed by the low address bits.

A retriggerable load window follows every accepted load. Once the window runs out with no new load, the buffered words are programmed together over one fixed programming period. `busy_o` is high for that period, and `done_o` pulses when it ends. While the period runs, a read of the last word loaded returns that word with bits 7 and 15 inverted. A host can poll that address to see when the write has finished.

Every duration is a clock-count parameter. A simulation can therefore use short windows, and silicon can use the full microsecond and millisecond values.

Top module: `eepw_ctrl`

## Requirements
- R1: A word load starts only when `oe_ni` is 1 and both `cs_ni` and `we_ni` are 0. The address is sampled in the first cycle that this condition holds, and later address changes during the pulse have no effect.
- R2: The load data is sampled in the first cycle in which `cs_ni` or `we_ni` is seen high again, after a qualified start.
- R3: A strobe pair that is active for fewer than `MIN_PULSE` consecutive cycles loads nothing and does not open or retrigger a load window.
- R4: If `oe_ni` is 0 while `cs_ni` and `we_ni` are both low, no load starts, so stored contents and `busy_o` are unaffected.
- R5: Each accepted load restarts the load window. `busy_o` rises once `LOAD_WIN` cycles pass with no accepted start and no load in progress.
- R6: Words are placed by address bits [`PAGE_W`-1:0], and all loaded words are programmed in one period. `busy_o` stays high for exactly `PROG_CYC` cycles whatever the word count. `done_o` pulses for one cycle as `busy_o` falls, and reads after that return the new data.
- R7: A load whose address bits above `PAGE_W` differ from those of the first load of the open page is ignored. It sets `page_err_o`, which stays 1 until reset.
- R8: Loads attempted while `busy_o` is 1 are ignored and change no stored word.
- R9: While `busy_o` is 1, a read of the last loaded address returns that word XOR 16'h8080. After programming ends, the true word is returned.
- R10: A read is `cs_ni`=0, `oe_ni`=0, `we_ni`=1, and `rdata_o` shows the result one cycle later. A read of any other address during `busy_o` returns the previously stored word. `rdata_o` is 0 when no read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low, pre-synchronised |
| we_ni | input | 1 | Write enable, active low, pre-synchronised |
| oe_ni | input | 1 | Output enable, active low, pre-synchronised |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data or polling value |
| busy_o | output | 1 | Programming period in progress |
| done_o | output | 1 | One-cycle pulse at end of programming |
| page_err_o | output | 1 | Sticky page-address mismatch flag |

## Verification
The bench spaces loads just under one window apart. A design that does not restart the window on each load would commit early, and `busy_o` would show it. It issues a two-cycle glitch and strobes with output enable held low, then reads back that the words are unchanged. A weak filter or a missing inhibit would corrupt them. During programming it polls the last word, an older word in the same page and a word on another page. This catches an inverted-bit polling value on the wrong address, or an array written before the period ends. It also sends a load from a different page and a load during busy, which a faulty design would store. It measures the busy length for one-word and three-word pages, which exposes any dependence on the word count.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } seq_state_e;
endpackage

// File: rtl/eepw_strobe.sv
module eepw_strobe #(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 16,
  parameter int MIN_PULSE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              accept_i,
  output logic              start_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic              loading_o,
  output logic              load_o,
  output logic [ADDR_W-1:0] load_addr_o,
  output logic [DATA_W-1:0] load_data_o
);
  localparam int CW = $clog2(MIN_PULSE + 1);

  logic          act;
  logic [CW-1:0] cnt_q;
  logic          qual_q;
  logic          abort;
  logic [ADDR_W-1:0] addr_q;

  assign act          = !cs_ni && !we_ni && oe_ni;
  assign start_o      = act && (cnt_q == CW'(MIN_PULSE - 1));
  assign start_addr_o = (cnt_q == '0) ? addr_i : addr_q;
  assign loading_o    = qual_q;
  assign load_o       = qual_q && (cs_ni || we_ni);
  assign abort        = qual_q && !cs_ni && !we_ni && !oe_ni;
  assign load_addr_o  = addr_q;
  assign load_data_o  = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      qual_q <= 1'b0;
      addr_q <= '0;
    end else begin
      if (!act) cnt_q <= '0;
      else if (cnt_q < CW'(MIN_PULSE)) cnt_q <= cnt_q + 1'b1;
      if (act && cnt_q == '0) addr_q <= addr_i;
      if (start_o && accept_i) qual_q <= 1'b1;
      else if (load_o || abort) qual_q <= 1'b0;
    end
  end
endmodule

// File: rtl/eepw_seq.sv
module eepw_seq
  import eepw_pkg::*;
#(
  parameter int LOAD_WIN = 18750,
  parameter int PROG_CYC = 1250000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       loading_i,
  output seq_state_e state_o,
  output logic       busy_o,
  output logic       commit_o,
  output logic       done_o
);
  localparam int WW = $clog2(LOAD_WIN + 1);
  localparam int PW = $clog2(PROG_CYC + 1);

  seq_state_e    state_q;
  logic [WW-1:0] win_q;
  logic [PW-1:0] prog_q;
  logic          done_q;

  assign state_o  = state_q;
  assign busy_o   = (state_q == ST_PROG);
  assign commit_o = busy_o && (prog_q == PW'(PROG_CYC - 1));
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
      prog_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= commit_o;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LOAD;
          win_q   <= '0;
        end
        ST_LOAD: begin
          if (start_i) win_q <= '0;
          else if (!loading_i) begin
            // window frozen while a strobe is held
            if (win_q == WW'(LOAD_WIN - 1)) begin
              state_q <= ST_PROG;
              prog_q  <= '0;
            end else win_q <= win_q + 1'b1;
          end
        end
        ST_PROG: begin
          if (commit_o) state_q <= ST_IDLE;
          else prog_q <= prog_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eepw_page_buf.sv
module eepw_page_buf #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 7
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               start_i,
  input  logic                               open_i,
  input  logic [ADDR_W-PAGE_W-1:0]           start_page_i,
  input  logic                               load_i,
  input  logic [PAGE_W-1:0]                  load_idx_i,
  input  logic [DATA_W-1:0]                  load_data_i,
  input  logic                               commit_i,
  output logic                               match_o,
  output logic [ADDR_W-PAGE_W-1:0]           page_o,
  output logic [(1<<PAGE_W)-1:0]             valid_o,
  output logic [(1<<PAGE_W)-1:0][DATA_W-1:0] words_o
);
  localparam int WORDS = 1 << PAGE_W;

  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic [WORDS-1:0]         valid_q;
  logic [WORDS-1:0][DATA_W-1:0] words_q;

  assign match_o = (start_page_i == page_q);
  assign page_o  = page_q;
  assign valid_o = valid_q;
  assign words_o = words_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q  <= '0;
      valid_q <= '0;
    end else begin
      if (start_i && !open_i) page_q <= start_page_i;
      if (commit_i) valid_q <= '0;
      else if (load_i) valid_q[load_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (load_i) words_q[load_idx_i] <= load_data_i;
  end
endmodule

// File: rtl/eepw_ctrl.sv
module eepw_ctrl
  import eepw_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 16,
  parameter int PAGE_W    = 7,
  parameter int MIN_PULSE = 3,
  parameter int LOAD_WIN  = 18750,
  parameter int PROG_CYC  = 1250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              page_err_o
);
  localparam int WORDS  = 1 << PAGE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int TAG_W  = ADDR_W - PAGE_W;

  function automatic logic [DATA_W-1:0] poll_mask();
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i % 8 == 7);
    return m;
  endfunction
  localparam logic [DATA_W-1:0] POLL_MASK = poll_mask();

  logic              start_raw, start_acc, loading_w, load_w, commit_w, match_w, open_w;
  logic [ADDR_W-1:0] start_addr_w, load_addr_w;
  logic [DATA_W-1:0] load_data_w;
  seq_state_e        state_w;
  logic [TAG_W-1:0]  page_w;
  logic [WORDS-1:0]  valid_w;
  logic [WORDS-1:0][DATA_W-1:0] words_w;

  logic [ADDR_W-1:0] last_addr_q;
  logic [DATA_W-1:0] last_data_q;
  logic              err_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] mem_q [DEPTH];

  assign open_w    = (state_w == ST_LOAD);
  assign start_acc = start_raw && !busy_o && (!open_w || match_w);

  eepw_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)) i_strobe (
    .clk_i, .rst_ni, .cs_ni, .we_ni, .oe_ni, .addr_i, .wdata_i,
    .accept_i     (start_acc),
    .start_o      (start_raw),
    .start_addr_o (start_addr_w),
    .loading_o    (loading_w),
    .load_o       (load_w),
    .load_addr_o  (load_addr_w),
    .load_data_o  (load_data_w)
  );

  eepw_seq #(.LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) i_seq (
    .clk_i, .rst_ni,
    .start_i   (start_acc),
    .loading_i (loading_w),
    .state_o   (state_w),
    .busy_o    (busy_o),
    .commit_o  (commit_w),
    .done_o    (done_o)
  );

  eepw_page_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) i_page (
    .clk_i, .rst_ni,
    .start_i      (start_acc),
    .open_i       (open_w),
    .start_page_i (start_addr_w[ADDR_W-1:PAGE_W]),
    .load_i       (load_w),
    .load_idx_i   (load_addr_w[PAGE_W-1:0]),
    .load_data_i  (load_data_w),
    .commit_i     (commit_w),
    .match_o      (match_w),
    .page_o       (page_w),
    .valid_o      (valid_w),
    .words_o      (words_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_addr_q <= '0;
      last_data_q <= '0;
      err_q       <= 1'b0;
      rdata_q     <= '0;
    end else begin
      if (load_w) begin
        last_addr_q <= load_addr_w;
        last_data_q <= load_data_w;
      end
      if (start_raw && !busy_o && open_w && !match_w) err_q <= 1'b1;
      if (!cs_ni && !oe_ni && we_ni)
        rdata_q <= (busy_o && addr_i == last_addr_q) ? (last_data_q ^ POLL_MASK)
                                                     : mem_q[addr_i];
      else rdata_q <= '0;
    end
  end

  // whole page lands in the array at the end of the period
  always_ff @(posedge clk_i) begin
    if (commit_w)
      for (int i = 0; i < WORDS; i++)
        if (valid_w[i]) mem_q[{page_w, PAGE_W'(i)}] <= words_w[i];
  end

  assign rdata_o    = rdata_q;
  assign page_err_o = err_q;
endmodule

// File: rtl/eepw_ctrl_chk.sv
module eepw_ctrl_chk #(
  parameter int MIN_PULSE = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic we_ni,
  input logic oe_ni,
  input logic busy_o,
  input logic done_o,
  input logic page_err_o,
  input logic start_raw,
  input logic start_acc,
  input logic load_w,
  input logic loading_w
);
  p_start_strobes_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_acc |-> (!cs_ni && !we_ni && oe_ni));

  p_no_glitch_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MIN_PULSE > 1 && start_raw) |-> $past(!cs_ni && !we_ni && oe_ni));

  p_idle_before_prog_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(!loading_w));

  p_done_ends_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_err_o |=> page_err_o);

  p_no_load_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !load_w);
endmodule

bind eepw_ctrl eepw_ctrl_chk #(.MIN_PULSE(MIN_PULSE)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .we_ni      (we_ni),
  .oe_ni      (oe_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .page_err_o (page_err_o),
  .start_raw  (start_raw),
  .start_acc  (start_acc),
  .load_w     (load_w),
  .loading_w  (loading_w)
);

// File: tb/test_eepw_ctrl.sv
module test_eepw_ctrl;
  localparam int AW = 9, DW = 16, PW = 7, MINP = 3, WIN = 24, PROG = 40;

  logic clk = 0, rst_ni = 0, cs_ni = 1, we_ni = 1, oe_ni = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata_o;
  logic busy_o, done_o, page_err_o;

  eepw_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW), .MIN_PULSE(MINP),
              .LOAD_WIN(WIN), .PROG_CYC(PROG)) i_eepw_ctrl (
    .clk_i(clk), .rst_ni, .cs_ni, .we_ni, .oe_ni, .addr_i(addr), .wdata_i(wdata),
    .rdata_o, .busy_o, .done_o, .page_err_o);

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] exp_q[$];
  string         req_q[$];
  event          rd_ev;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // monitor: pops expected read data as each read result appears
  initial forever begin
    @(rd_ev);
    chk(req_q.pop_front(), 32'(rdata_o), 32'(exp_q.pop_front()));
  end

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, int hold = 4, bit oe_lo = 0);
    @(negedge clk); addr = a; wdata = ~d; oe_ni = !oe_lo; cs_ni = 0; we_ni = 0;
    @(negedge clk); addr = a ^ 9'h011;
    repeat (hold - 2) @(negedge clk);
    wdata = d;
    @(negedge clk); we_ni = 1;
    @(negedge clk); cs_ni = 1; oe_ni = 1;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [DW-1:0] e, string r);
    @(negedge clk); addr = a; cs_ni = 0; oe_ni = 0; we_ni = 1;
    exp_q.push_back(e); req_q.push_back(r);
    @(negedge clk); -> rd_ev;
    cs_ni = 1; oe_ni = 1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_busy();
    for (int i = 0; i < 500 && !busy_o; i++) @(negedge clk);
  endtask

  task automatic measure_prog(string r);
    int cyc = 0;
    wait_busy();
    while (busy_o && cyc < 1000) begin cyc++; @(negedge clk); end
    chk({r, " busy length"}, 32'(cyc), 32'(PROG));
    chk({r, " done pulse"}, 32'(done_o), 32'd1);
    @(negedge clk);
    chk({r, " done single cycle"}, 32'(done_o), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(4);
    rst_ni = 1;
    idle(1);
    chk("R10 reset rdata", 32'(rdata_o), 32'd0);
    chk("R5 reset busy", 32'(busy_o), 32'd0);
    chk("R6 reset done", 32'(done_o), 32'd0);
    chk("R7 reset err", 32'(page_err_o), 32'd0);

    // single word page
    wr(9'h100, 16'h1234);
    idle(WIN - 6);
    chk("R5 busy still low inside window", 32'(busy_o), 32'd0);
    measure_prog("R6 one word");
    rd(9'h100, 16'h1234, "R1 R2 R6 readback");

    // three words with gaps just under the window
    wr(9'h003, 16'hB003);
    idle(WIN - 8);
    wr(9'h004, 16'hB004);
    idle(WIN - 8);
    chk("R5 retrigger keeps busy low", 32'(busy_o), 32'd0);
    wr(9'h005, 16'hB005);
    wr(9'h100, 16'hDEAD);
    chk("R7 page mismatch flag", 32'(page_err_o), 32'd1);
    wait_busy();
    chk("R5 busy after window", 32'(busy_o), 32'd1);
    rd(9'h005, 16'hB005 ^ 16'h8080, "R9 polling last word");
    rd(9'h100, 16'h1234, "R10 other page during busy");
    wr(9'h004, 16'hEEEE);
    for (int i = 0; i < 200 && busy_o; i++) @(negedge clk);
    idle(2);
    chk("R7 flag sticky", 32'(page_err_o), 32'd1);
    rd(9'h003, 16'hB003, "R6 word 3");
    rd(9'h004, 16'hB004, "R8 load during busy ignored");
    rd(9'h005, 16'hB005, "R9 true data after done");
    rd(9'h100, 16'h1234, "R7 mismatched load dropped");

    // same page rewrite, old data visible during busy
    wr(9'h003, 16'hC003);
    wr(9'h006, 16'hC006);
    wait_busy();
    rd(9'h003, 16'hB003, "R10 same page old data during busy");
    rd(9'h006, 16'hC006 ^ 16'h8080, "R9 polling second page");
    for (int i = 0; i < 200 && busy_o; i++) @(negedge clk);
    idle(2);
    rd(9'h003, 16'hC003, "R6 rewrite landed");

    // multi word period length
    wr(9'h187, 16'h7007);
    wr(9'h188, 16'h8008);
    wr(9'h189, 16'h9009);
    measure_prog("R6 three words");
    rd(9'h188, 16'h8008, "R6 multi word data");

    // glitch and output-enable inhibit
    wr(9'h003, 16'h0BAD, 2);
    idle(WIN + 10);
    chk("R3 glitch no window", 32'(busy_o), 32'd0);
    rd(9'h003, 16'hC003, "R3 glitch no write");
    wr(9'h003, 16'h0BAD, 4, 1);
    idle(WIN + 10);
    chk("R4 oe low no window", 32'(busy_o), 32'd0);
    rd(9'h003, 16'hC003, "R4 oe low no write");
    idle(2);
    chk("R10 rdata zero when idle", 32'(rdata_o), 32'd0);

    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule